// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sorts a 32-bit virtual address into one of the fixed segments of a classic 32-bit processor address map. For each accepted request it gives one of three outcomes: a direct physical address with read and write permission, a request to the translation lookaside buffer (TLB) for a lookup, or an address error. The result depends on the privilege level of the access and on the error-level status bit.

An optional remap mode serves a guest kernel that has to run inside the user range. When it is on, the upper half of the user segment is moved onto kernel segment addresses before the address is classified. Any TLB request still carries the address exactly as it was presented, so the translation is done on the guest's own address.

Each request is accepted on a single-cycle strobe. The outcome appears on registered outputs one clock later and stays valid for one cycle.

Top module: `vseg_decoder`

## Requirements
- R1: With `remap_en` high, a raw address in [0x40000000, 0x5FFFFFFF] is offset by +0x40000000 before classification, so it is handled as kernel segment 0 (in kernel mode the physical address is the raw address minus 0x40000000).
- R2: With `remap_en` high, a raw address in [0x60000000, 0x7FFFFFFF] is offset by +0x60000000 before classification, so it falls in the supervisor segment at 0xC0000000 to 0xDFFFFFFF.
- R3: An effective address at or below 0x7FFFFFFF maps directly to a physical address equal to itself when `err_level` is 1. When `err_level` is 0 it raises a TLB request, at every privilege level.
- R4: An effective address in [0x80000000, 0x9FFFFFFF] maps directly to the effective address minus 0x80000000 in kernel mode (`priv` = 2'b10). At any other level it raises an address error.
- R5: An effective address in [0xA0000000, 0xBFFFFFFF] maps directly to the effective address minus 0xA0000000 in kernel mode. At any other level it raises an address error.
- R6: An effective address in [0xC0000000, 0xDFFFFFFF] raises a TLB request in supervisor mode (`priv` = 2'b01) or kernel mode. Otherwise it raises an address error.
- R7: An effective address at or above 0xE0000000 raises a TLB request only in kernel mode. Otherwise it raises an address error. The `priv` code 2'b11 is reserved and is treated as user (2'b00).
- R8: A TLB request carries the raw, pre-remap address on `tlb_vaddr` and the access direction on `tlb_write`. Both are zero when no TLB request is made.
- R9: A direct map sets both `perm_rd` and `perm_wr`. Both are zero for a TLB request or an address error, and `paddr` is zero whenever there is no direct map.
- R10: One cycle after a `req_valid` strobe, `out_valid` is high and exactly one of `map_valid`, `tlb_req` and `addr_err` is high. In any cycle that does not follow a strobe, all outcome outputs are zero.
- R11: With `remap_en` low, raw addresses in [0x40000000, 0x7FFFFFFF] follow the user-segment rules of R3.
- R12: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, one cycle per address |
| vaddr | input | 32 | Raw virtual address |
| priv | input | 2 | Privilege level: 00 user, 01 supervisor, 10 kernel, 11 reserved (user) |
| err_level | input | 1 | Error-level status bit |
| is_write | input | 1 | Access direction, 1 for a write |
| remap_en | input | 1 | Enables the guest-kernel remap of the upper user range |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| map_valid | output | 1 | Direct map outcome |
| paddr | output | 32 | Physical address for a direct map |
| perm_rd | output | 1 | Read permission for a direct map |
| perm_wr | output | 1 | Write permission for a direct map |
| tlb_req | output | 1 | TLB lookup outcome |
| tlb_vaddr | output | 32 | Raw address sent to the TLB |
| tlb_write | output | 1 | Access direction sent to the TLB |
| addr_err | output | 1 | Address error outcome |

## Verification
Two functions can decide the same request: the remap window, and the error-level rule that applies to the user segment. Both can act on an address in the upper user range. The bench drives raw addresses from 0x40000000 to 0x7FFFFFFF with `remap_en` and `err_level` set together, at every privilege level, in directed cases and in random ones. The result is judged against a bench model in which the remap moves the address out of the user segment first, so the error-level rule no longer applies. A user-mode access therefore has to give an address error rather than a direct map, and a kernel access to the first window has to map to the raw address minus 0x40000000. In the second window the TLB request has to carry the raw address, not the offset one.

// File: rtl/vseg_decoder.sv
module vseg_decoder #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] vaddr,
  input  logic [1:0]    priv,
  input  logic          err_level,
  input  logic          is_write,
  input  logic          remap_en,
  output logic          out_valid,
  output logic          map_valid,
  output logic [AW-1:0] paddr,
  output logic          perm_rd,
  output logic          perm_wr,
  output logic          tlb_req,
  output logic [AW-1:0] tlb_vaddr,
  output logic          tlb_write,
  output logic          addr_err
);

  localparam logic [AW-1:0] USER_TOP  = AW'(32'h7FFF_FFFF);
  localparam logic [AW-1:0] K0_BASE   = AW'(32'h8000_0000);
  localparam logic [AW-1:0] K1_BASE   = AW'(32'hA000_0000);
  localparam logic [AW-1:0] K2_BASE   = AW'(32'hC000_0000);
  localparam logic [AW-1:0] K3_BASE   = AW'(32'hE000_0000);
  localparam logic [AW-1:0] WIN0_BASE = AW'(32'h4000_0000);
  localparam logic [AW-1:0] WIN2_BASE = AW'(32'h6000_0000);

  logic          in_win0, in_win2;
  logic [AW-1:0] eff;
  logic          kern, sup;
  logic          c_map, c_tlb, c_err;
  logic [AW-1:0] c_pa;

  assign in_win0 = remap_en && (vaddr >= WIN0_BASE) && (vaddr < WIN2_BASE);
  assign in_win2 = remap_en && (vaddr >= WIN2_BASE) && (vaddr <= USER_TOP);
  assign eff = in_win0 ? vaddr + (K0_BASE - WIN0_BASE) :
               in_win2 ? vaddr + (K2_BASE - WIN2_BASE) : vaddr;

  assign kern = (priv == 2'b10);
  assign sup  = (priv == 2'b01);

  always_comb begin
    c_map = 1'b0;
    c_tlb = 1'b0;
    c_err = 1'b0;
    c_pa  = '0;
    if (eff <= USER_TOP) begin
      if (err_level) begin
        c_map = 1'b1;
        c_pa  = eff;
      end else begin
        c_tlb = 1'b1;
      end
    end else if (eff < K1_BASE) begin
      if (kern) begin
        c_map = 1'b1;
        c_pa  = eff - K0_BASE;
      end else begin
        c_err = 1'b1;
      end
    end else if (eff < K2_BASE) begin
      if (kern) begin
        c_map = 1'b1;
        c_pa  = eff - K1_BASE;
      end else begin
        c_err = 1'b1;
      end
    end else if (eff < K3_BASE) begin
      c_tlb = kern || sup;
      c_err = !(kern || sup);
    end else begin
      c_tlb = kern;
      c_err = !kern;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      map_valid <= 1'b0;
      paddr     <= '0;
      perm_rd   <= 1'b0;
      perm_wr   <= 1'b0;
      tlb_req   <= 1'b0;
      tlb_vaddr <= '0;
      tlb_write <= 1'b0;
      addr_err  <= 1'b0;
    end else begin
      out_valid <= req_valid;
      map_valid <= req_valid && c_map;
      paddr     <= (req_valid && c_map) ? c_pa : '0;
      perm_rd   <= req_valid && c_map;
      perm_wr   <= req_valid && c_map;
      tlb_req   <= req_valid && c_tlb;
      tlb_vaddr <= (req_valid && c_tlb) ? vaddr : '0;
      tlb_write <= req_valid && c_tlb && is_write;
      addr_err  <= req_valid && c_err;
    end
  end

endmodule

// File: rtl/vseg_decoder_chk.sv
module vseg_decoder_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] vaddr,
  input logic [1:0]    priv,
  input logic          err_level,
  input logic          is_write,
  input logic          out_valid,
  input logic          map_valid,
  input logic [AW-1:0] paddr,
  input logic          perm_rd,
  input logic          perm_wr,
  input logic          tlb_req,
  input logic [AW-1:0] tlb_vaddr,
  input logic          tlb_write,
  input logic          addr_err
);

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid) |-> out_valid); // R10

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones({map_valid, tlb_req, addr_err}) == 1)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(map_valid || tlb_req || addr_err || perm_rd || perm_wr)); // R10

  AST_PERM_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid |-> (perm_rd && perm_wr)); // R9

  AST_PERM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req || addr_err) |-> (!perm_rd && !perm_wr && paddr == '0)); // R9

  AST_TLB_RAW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req && $past(req_valid)) |-> (tlb_vaddr == $past(vaddr) && tlb_write == $past(is_write))); // R8

  AST_K3_KERNEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(req_valid) && $past(vaddr) >= AW'(32'hE000_0000) && $past(priv) != 2'b10)
      |-> addr_err); // R7

endmodule

bind vseg_decoder vseg_decoder_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vaddr(vaddr),
  .priv(priv), .err_level(err_level), .is_write(is_write),
  .out_valid(out_valid), .map_valid(map_valid), .paddr(paddr),
  .perm_rd(perm_rd), .perm_wr(perm_wr), .tlb_req(tlb_req),
  .tlb_vaddr(tlb_vaddr), .tlb_write(tlb_write), .addr_err(addr_err)
);

// File: tb/vseg_decoder_tb.sv
module vseg_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  priv = '0;
  logic        err_level = 1'b0;
  logic        is_write = 1'b0;
  logic        remap_en = 1'b0;
  logic        out_valid, map_valid, perm_rd, perm_wr, tlb_req, tlb_write, addr_err;
  logic [31:0] paddr, tlb_vaddr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vseg_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vaddr(vaddr),
    .priv(priv), .err_level(err_level), .is_write(is_write), .remap_en(remap_en),
    .out_valid(out_valid), .map_valid(map_valid), .paddr(paddr),
    .perm_rd(perm_rd), .perm_wr(perm_wr), .tlb_req(tlb_req),
    .tlb_vaddr(tlb_vaddr), .tlb_write(tlb_write), .addr_err(addr_err)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // model: kind 0 map, 1 tlb, 2 error
  function automatic int model(input logic [31:0] a, input logic [1:0] p, input bit erl,
                               input bit rm, output logic [31:0] pa, output string tag);
    logic [31:0] e;
    bit k, s;
    int kind;
    e = a;
    tag = "";
    if (rm && a >= 32'h4000_0000 && a < 32'h6000_0000) begin e = a + 32'h4000_0000; tag = "R1"; end
    else if (rm && a >= 32'h6000_0000 && a <= 32'h7FFF_FFFF) begin e = a + 32'h6000_0000; tag = "R2"; end
    k = (p == 2'b10);
    s = (p == 2'b01);
    pa = '0;
    if (e <= 32'h7FFF_FFFF) begin
      if (tag == "") tag = (a >= 32'h4000_0000) ? "R11" : "R3";
      if (erl) begin kind = 0; pa = e; end else kind = 1;
    end else if (e < 32'hA000_0000) begin
      if (tag == "") tag = "R4";
      if (k) begin kind = 0; pa = e - 32'h8000_0000; end else kind = 2;
    end else if (e < 32'hC000_0000) begin
      if (tag == "") tag = "R5";
      if (k) begin kind = 0; pa = e - 32'hA000_0000; end else kind = 2;
    end else if (e < 32'hE000_0000) begin
      if (tag == "") tag = "R6";
      kind = (k || s) ? 1 : 2;
    end else begin
      if (tag == "") tag = "R7";
      kind = k ? 1 : 2;
    end
    return kind;
  endfunction

  task automatic run(input logic [31:0] a, input logic [1:0] p, input bit erl,
                     input bit wr, input bit rm);
    logic [31:0] pa;
    string tag;
    int kind;
    logic [2:0] exp_oh, act_oh;
    kind = model(a, p, erl, rm, pa, tag);
    @(negedge clk);
    vaddr = a; priv = p; err_level = erl; is_write = wr; remap_en = rm; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    exp_oh = (kind == 0) ? 3'b100 : (kind == 1) ? 3'b010 : 3'b001;
    act_oh = {map_valid, tlb_req, addr_err};
    check(out_valid && act_oh == exp_oh, {tag, " outcome R10"}, {out_valid, act_oh}, {1'b1, exp_oh});
    check(paddr == pa, {tag, " paddr R9"}, paddr, pa);
    check(perm_rd == (kind == 0) && perm_wr == (kind == 0), "R9 perm", {perm_rd, perm_wr}, {2{kind == 0}});
    check(tlb_vaddr == ((kind == 1) ? a : 32'h0) && tlb_write == ((kind == 1) && wr),
          "R8 tlb addr", {tlb_write, tlb_vaddr}, {(kind == 1) && wr, (kind == 1) ? a : 32'h0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R12 reset state
    check({out_valid, map_valid, perm_rd, perm_wr, tlb_req, tlb_write, addr_err} == 7'b0 &&
          paddr == 0 && tlb_vaddr == 0, "R12 reset", {out_valid, map_valid, tlb_req, addr_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run(32'h0000_0000, 2'b00, 1'b0, 1'b1, 1'b0); // R3 tlb
    run(32'h7FFF_FFFF, 2'b00, 1'b1, 1'b0, 1'b0); // R3 direct via ERL
    run(32'h4000_0000, 2'b00, 1'b1, 1'b0, 1'b0); // R11
    run(32'h6123_4567, 2'b10, 1'b0, 1'b1, 1'b0); // R11
    run(32'h4000_0000, 2'b10, 1'b0, 1'b0, 1'b1); // R1 kernel
    run(32'h5FFF_FFFF, 2'b10, 1'b1, 1'b0, 1'b1); // R1 with ERL
    run(32'h4ABC_0000, 2'b00, 1'b1, 1'b0, 1'b1); // R1 user error despite ERL
    run(32'h6000_0000, 2'b01, 1'b0, 1'b1, 1'b1); // R2 supervisor tlb raw addr
    run(32'h7FFF_FFFF, 2'b00, 1'b1, 1'b0, 1'b1); // R2 user error
    run(32'h3FFF_FFFF, 2'b00, 1'b1, 1'b0, 1'b1); // below window
    run(32'h8000_0000, 2'b10, 1'b0, 1'b0, 1'b0); // R4
    run(32'h9FFF_FFFF, 2'b01, 1'b0, 1'b0, 1'b0); // R4 error
    run(32'hA000_0000, 2'b10, 1'b0, 1'b0, 1'b0); // R5
    run(32'hBFFF_FFFF, 2'b00, 1'b1, 1'b0, 1'b0); // R5 error
    run(32'hC000_0000, 2'b01, 1'b0, 1'b1, 1'b0); // R6
    run(32'hDFFF_FFFF, 2'b00, 1'b0, 1'b0, 1'b0); // R6 error
    run(32'hE000_0000, 2'b10, 1'b0, 1'b1, 1'b0); // R7
    run(32'hFFFF_FFFF, 2'b01, 1'b0, 1'b0, 1'b0); // R7 error
    run(32'hF000_0000, 2'b11, 1'b0, 1'b0, 1'b0); // R7 reserved code
    run(32'hC800_0000, 2'b11, 1'b0, 1'b0, 1'b0); // R7 reserved as user
    // R10 idle cycle after a strobe
    @(negedge clk);
    check(!out_valid && !map_valid && !tlb_req && !addr_err, "R10 idle",
          {out_valid, map_valid, tlb_req, addr_err}, 0);
    // random mix, biased toward the upper user range with both remap and ERL
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      a = $urandom;
      if (i % 3 == 0) a = {2'b01, a[29:0]};
      run(a, 2'($urandom), 1'($urandom), 1'($urandom), (i % 3 == 0) ? 1'b1 : 1'($urandom));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule